// File: doc/BRIEF.md
# Programmable Delay Line Buffer

This block delays a stream of 10-bit words by a latency chosen at run time, anywhere from 2 to 1281 clock cycles. The path runs through an entry register, a memory-based delay section and an exit register. The two registers give two fixed cycles. An 11-bit length word, which holds the wanted latency minus two, sets how many cycles the memory adds. The length is loaded synchronously under a load strobe.

A second mode closes the loop. The exit register feeds the entry register instead of the data input, so the block keeps cycling the last N words it captured and acts as a circular store of N words. Mode can change between any two cycles. An active-high freeze input stops every register and the memory one cycle after it is sampled. An active-high output-off input forces the output to zero and drops a valid flag. Data keeps moving inside while the output is off.

Top module: `prog_delay_line`

## Requirements
- R1: In delay mode (`recirc` low), the word on `din` at an enabled rising edge appears on `dout` after edge number N, where that edge counts as number 1 and N = programmed length + 2. Results hold once N enabled edges have passed since the last length load.
- R2: After reset, `dout` is 0 and `dout_vld` is 1 while `out_off` is low. The length register is 0, so the latency is 2 cycles. The block is enabled and in delay mode.
- R3: A length word above 1279 is clamped to 1279, which gives a latency of 1281 cycles.
- R4: The length register changes only on an enabled edge where `len_load` is high. A new `len_in` with `len_load` low, or a load pulse while the block is frozen, leaves the latency unchanged.
- R5: With `recirc` high, `din` is ignored and the entry register takes the exit register's word. After the loop has been filled in delay mode, `dout` repeats the last N captured words with period N.
- R6: `freeze` high at edge k leaves edge k active and holds all state, including `dout`, at every following edge until one edge after `freeze` is sampled low again.
- R7: With `out_off` high, `dout` is all zeros and `dout_vld` is 0. Internal data keeps moving, so once `out_off` goes low the output shows the word that delay mode would have produced.
- R8: A programmed length of 0 skips the memory and gives a latency of 2 cycles.
- R9: When `recirc` drops, the block captures `din` again at that same edge, and that word comes out N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Input data word |
| len_in | input | 11 | Wanted latency minus two |
| len_load | input | 1 | Strobe that loads `len_in` |
| recirc | input | 1 | 1 = circular store, 0 = delay line |
| freeze | input | 1 | 1 = hold all state, from the next edge on |
| out_off | input | 1 | 1 = mask the output to zero |
| dout | output | 10 | Delayed data word |
| dout_vld | output | 1 | High when `dout` is driven |

## Verification
The bench measures latency at the shortest setting, at a middle value, and at the clamped top setting. A pointer that wraps one slot early or late shifts every word by a cycle, and a missing clamp lets the pointer run past the memory. It freezes the block in the middle of a stream and pulses a length load while frozen. If the enable were not registered, the first frozen edge would go missing. If the load were not gated, the latency would change. It also fills the loop, switches to recirculate and checks the period. Then it switches back and checks that fresh input comes out after N cycles, which catches a loop that is off by one cycle or a mode change that lands one edge late.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
   localparam int PDL_DATA_W  = 10;
   localparam int PDL_LEN_W   = 11;
   localparam int PDL_MAX_LEN = 1279;

   typedef enum logic {
      PDL_MODE_DELAY = 1'b0,
      PDL_MODE_LOOP  = 1'b1
   } pdl_mode_e;
endpackage

// File: rtl/pdl_len_reg.sv
module pdl_len_reg #(
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1279
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [LEN_W-1:0] len_in,
   output logic [LEN_W-1:0] len_q
);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

   logic [LEN_W-1:0] len_cap;

   generate
      if (MAX_LEN == (2 ** LEN_W) - 1) begin : g_full_range
         assign len_cap = len_in;
      end else begin : g_clamp
         assign len_cap = (len_in > CAP) ? CAP : len_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         len_q <= '0;
      else if (en && load)
         len_q <= len_cap;
   end

   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && load) |=> $stable(len_q)) else $error("length changed without load"); // R4
   AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && load && (len_in > CAP)) |=> (len_q == CAP)) else $error("length not clamped"); // R3
endmodule

// File: rtl/pdl_ram_delay.sv
module pdl_ram_delay #(
   parameter int DATA_W  = 10,
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1279
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = MAX_LEN;
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  ptr_nxt;
   logic              wrap;
   logic              bypass;

   assign bypass  = (len == '0);
   assign wrap    = (((LEN_W+1)'(ptr)) + (LEN_W+1)'(1)) >= {1'b0, len};
   assign ptr_nxt = wrap ? '0 : ptr + PTR_W'(1);

   // read-first: q takes the old word while the same slot is rewritten
   always_ff @(posedge clk) begin
      if (en && !bypass)
         mem[ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         q   <= '0;
      end else if (en) begin
         ptr <= bypass ? '0 : ptr_nxt;
         q   <= bypass ? wdata : mem[ptr];
      end
   end

   AST_BYPASS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && bypass) |=> (q == $past(wdata))) else $error("zero length not bypassed"); // R8
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(q) && $stable(ptr))) else $error("delay moved while frozen"); // R6
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
   import pdl_pkg::*;
#(
   parameter int DATA_W  = PDL_DATA_W,
   parameter int LEN_W   = PDL_LEN_W,
   parameter int MAX_LEN = PDL_MAX_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              len_load,
   input  logic              recirc,
   input  logic              freeze,
   input  logic              out_off,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if ((MAX_LEN < 1) || (MAX_LEN > (2 ** LEN_W) - 1)) begin : g_bad_len
         $error("MAX_LEN must fit in LEN_W bits and be at least 1");
      end
   endgenerate

   logic              en_q;
   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] q;
   logic [LEN_W-1:0]  len_q;
   pdl_mode_e         mode;

   assign mode = pdl_mode_e'(recirc);

   // freeze acts one edge late: its sample is registered first
   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b1;
      else
         en_q <= !freeze;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         in_q <= '0;
      else if (en_q)
         in_q <= (mode == PDL_MODE_LOOP) ? q : din;
   end

   pdl_len_reg #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_q),
      .load   (len_load),
      .len_in (len_in),
      .len_q  (len_q)
   );

   pdl_ram_delay #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .len   (len_q),
      .wdata (in_q),
      .q     (q)
   );

   assign dout     = out_off ? '0 : q;
   assign dout_vld = !out_off;

   AST_LOOP_FEED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && recirc) |=> (in_q == $past(q))) else $error("loop not fed from output"); // R5
   AST_DELAY_FEED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !recirc) |=> (in_q == $past(din))) else $error("input not captured"); // R1
   AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> ($stable(in_q) && $stable(len_q))) else $error("state moved while frozen"); // R6
endmodule

// File: tb/prog_delay_line_test.sv
module prog_delay_line_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  din = '0;
   logic [10:0] len_in = '0;
   logic        len_load = 1'b0;
   logic        recirc = 1'b0;
   logic        freeze = 1'b0;
   logic        out_off = 1'b0;
   logic [9:0]  dout;
   logic        dout_vld;

   int checks = 0;
   int errors = 0;

   prog_delay_line uut (
      .clk(clk), .rst_n(rst_n), .din(din), .len_in(len_in), .len_load(len_load),
      .recirc(recirc), .freeze(freeze), .out_off(out_off), .dout(dout), .dout_vld(dout_vld)
   );

   always #5 clk = ~clk;

   function automatic logic [9:0] pat(int e, int s);
      return 10'((e * 37 + s * 101 + 5) & 1023);
   endfunction

   task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic load_len(logic [10:0] v);
      len_in   = v;
      len_load = 1'b1;
      tick();
      len_load = 1'b0;
   endtask

   // feeds a pattern; edge e output must be the word sent at edge e-n+1
   task automatic run_delay(string req, int n, int cycles, int seed);
      for (int e = 0; e < cycles; e++) begin
         din = pat(e, seed);
         tick();
         if (e >= n - 1) chk(req, dout, pat(e - n + 1, seed));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      chk("R2 dout", dout, 10'h000);
      chk("R2 vld", {9'd0, dout_vld}, 10'h001);
      rst_n = 1'b1;
      run_delay("R2 latency", 2, 6, 1);
   endtask

   task automatic t_lengths();
      load_len(11'd5);
      run_delay("R1", 7, 20, 2);
      load_len(11'd0);
      run_delay("R8", 2, 8, 3);
      load_len(11'd2047);
      run_delay("R3", 1281, 1290, 4);
   endtask

   task automatic t_noload();
      load_len(11'd3);
      len_in = 11'd9;
      run_delay("R4 noload", 5, 15, 5);
   endtask

   task automatic t_hold();
      logic [9:0] held;
      load_len(11'd2);
      for (int e = 0; e < 8; e++) begin
         din = pat(e, 6);
         tick();
      end
      freeze = 1'b1;
      din = pat(8, 6);
      tick();
      chk("R6 last active", dout, pat(5, 6));
      held = dout;
      for (int k = 0; k < 2; k++) begin
         din      = 10'h3FF ^ 10'(k);
         len_in   = 11'd7;
         len_load = 1'b1;
         freeze   = (k == 0);
         tick();
         chk("R6 frozen", dout, held);
      end
      len_load = 1'b0;
      for (int e = 9; e < 21; e++) begin
         din = pat(e, 6);
         tick();
         chk("R6 R4 resume", dout, pat(e - 3, 6));
      end
   endtask

   task automatic t_oe();
      load_len(11'd1);
      for (int e = 0; e < 12; e++) begin
         din     = pat(e, 7);
         out_off = (e >= 4 && e < 8);
         tick();
         if (out_off) begin
            chk("R7 masked", dout, 10'h000);
            chk("R7 vld low", {9'd0, dout_vld}, 10'h000);
         end else if (e >= 2) begin
            chk("R7 data", dout, pat(e - 2, 7));
            chk("R7 vld high", {9'd0, dout_vld}, 10'h001);
         end
      end
      out_off = 1'b0;
   endtask

   task automatic t_recirc();
      load_len(11'd3);
      for (int e = 0; e < 5; e++) begin
         din = pat(e, 8);
         tick();
      end
      recirc = 1'b1;
      for (int e = 5; e < 21; e++) begin
         din = 10'h155 ^ 10'(e);
         tick();
         chk("R5 loop", dout, pat((e - 4) % 5, 8));
      end
      recirc = 1'b0;
      for (int j = 0; j < 10; j++) begin
         din = pat(j, 9);
         tick();
         if (j >= 4) chk("R9 back to delay", dout, pat(j - 4, 9));
      end
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2;
      t_reset();
      t_lengths();
      t_noload();
      t_hold();
      t_oe();
      t_recirc();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule